// File: doc/BRIEF.md
# MFM Write Precompensation Unit

This block sits between an MFM encoder and the drive write line. It takes one strobe per bit cell. With each strobe come the data bit of that cell and a flag that says whether the cell's clock slot carries a flux transition. From these it rebuilds the write pulse train on a timeline of clock ticks. A pulse in a data slot is moved a few ticks earlier or later when its neighbouring data bits are spaced unevenly. On the media, closely packed transitions drift apart. Moving the pulse the other way in advance cancels that drift.

The design assumes a 24 MHz tick, so one tick is about 41.7 ns. The shift size is chosen per cell from a 3-bit setting and the rate select. The setting can take the rate's default (three ticks, or one tick at the fastest rate), a fixed count of one to six ticks, or no shift at all. Pulse positions are taken against a nominal offset of six ticks, which leaves room for the largest early shift. A cell is released when the strobe of the following cell arrives, because the data bit after it decides its shift.

Top module: `mfm_precomp`

## Requirements
- R1: While reset is high and in the first cycle after reset, `wr_pulse_o` is low, and no pulse appears until a cell has been released.
- R2: A cell is released when the next strobe is sampled at clock edge E. If the released cell's clock flag is set, a one-cycle pulse is visible right after edge E+6.
- R3: Rate codes map to half-cell lengths: 0 is 24 ticks, 1 is 40, 2 is 48 and 3 is 12. A released cell with data bit 1 gets a pulse after edge E+H+6+s, where H is the half-cell length and s is the signed shift. If the data bits before and after the cell are equal, s is 0.
- R4: If the previous data bit is 1 and the next is 0 (pattern 1,1,0), s equals minus the effective delay.
- R5: If the previous data bit is 0 and the next is 1 (pattern 0,1,1), s equals plus the effective delay.
- R6: Setting 0 with enable high gives a delay of 3 ticks for rate codes 0, 1 and 2, and 1 tick for rate code 3.
- R7: Settings 1 to 6 with enable high give a delay of that many ticks.
- R8: Setting 7, or enable low, gives a delay of 0. Every data pulse then sits at its nominal position.
- R9: Output pulses are one cycle wide. When strobes are spaced one full cell apart, output pulses keep the order of the slots they came from, and no two pulses merge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock (24 MHz in the target system) |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb_i | input | 1 | One-cycle strobe at the start of each bit cell |
| bit_i | input | 1 | Data bit of the cell marked by the strobe |
| clk_pls_i | input | 1 | High when the cell's clock slot carries a transition |
| rate_i | input | 2 | Rate code; sets the half-cell length and the default delay |
| pc_set_i | input | 3 | Delay setting: 0 default, 1 to 6 ticks, 7 off |
| pc_en_i | input | 1 | Enables precompensation; when low, no shift is applied |
| wr_pulse_o | output | 1 | Adjusted write pulse train |

## Verification
The bench builds the block with its default parameters: a six-tick maximum, defaults of three and one ticks, and half cells of 12, 24, 40 and 48 ticks. With these values it sweeps all four rate codes against all eight settings, and also runs segments with enable low. At the 12-tick half cell, a six-tick shift pushes an early data pulse within six ticks of its own clock pulse, and a late one within six ticks of the next cell's clock pulse. That tests ordering at its tightest. Each segment contains fixed 1,1,0 and 0,1,1 runs as well as seeded random bits. Every pulse time is compared with a schedule that the bench predicts.

// File: rtl/fdc_precomp_pkg.sv
package fdc_precomp_pkg;

    typedef enum logic [1:0] {
        SHIFT_NONE  = 2'd0,
        SHIFT_EARLY = 2'd1,
        SHIFT_LATE  = 2'd2
    } shift_e;

    // One released bit cell, as handed from the window to the scheduler.
    typedef struct packed {
        logic   valid;
        logic   clk_pls;
        logic   dat_pls;
        shift_e dir;
    } cell_ev_t;

    // Shift direction from the data bits around a data pulse.
    function automatic shift_e classify(input logic prev_b, input logic cur_b,
                                        input logic next_b);
        if (cur_b && prev_b && !next_b)
            return SHIFT_EARLY;
        else if (cur_b && !prev_b && next_b)
            return SHIFT_LATE;
        else
            return SHIFT_NONE;
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/precomp_delay_sel.sv
module precomp_delay_sel #(
    parameter int MAX_DLY  = 6,
    parameter int DEF_SLOW = 3,
    parameter int DEF_FAST = 1,
    parameter int HALF_R0  = 24,
    parameter int HALF_R1  = 40,
    parameter int HALF_R2  = 48,
    parameter int HALF_R3  = 12,
    parameter int SET_W    = 3,
    parameter int DW       = 3,
    parameter int HW       = 6
) (
    input  logic [1:0]       rate_i,
    input  logic [SET_W-1:0] set_i,
    input  logic             en_i,
    output logic [DW-1:0]    dly_o,
    output logic [HW-1:0]    half_o
);

    always_comb begin
        case (rate_i)
            2'd0:    half_o = HW'(HALF_R0);
            2'd1:    half_o = HW'(HALF_R1);
            2'd2:    half_o = HW'(HALF_R2);
            default: half_o = HW'(HALF_R3);
        endcase
    end

    always_comb begin
        if (!en_i || set_i == '1)
            dly_o = '0;
        else if (set_i == '0)
            dly_o = (rate_i == 2'd3) ? DW'(DEF_FAST) : DW'(DEF_SLOW);
        else if (int'(set_i) > MAX_DLY)
            dly_o = DW'(MAX_DLY);
        else
            dly_o = DW'(set_i);
    end

endmodule

// File: rtl/precomp_window.sv
module precomp_window
    import fdc_precomp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     stb_i,
    input  logic     bit_i,
    input  logic     clkp_i,
    output cell_ev_t ev_o
);

    logic have_cur_q;
    logic cur_bit_q;
    logic cur_clk_q;
    logic prev_bit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_cur_q <= 1'b0;
            cur_bit_q  <= 1'b0;
            cur_clk_q  <= 1'b0;
            prev_bit_q <= 1'b0;
        end else if (stb_i) begin
            have_cur_q <= 1'b1;
            prev_bit_q <= cur_bit_q;
            cur_bit_q  <= bit_i;
            cur_clk_q  <= clkp_i;
        end
    end

    // The incoming strobe carries the look-ahead bit that releases the held cell.
    always_comb begin
        ev_o.valid   = stb_i && have_cur_q;
        ev_o.clk_pls = cur_clk_q;
        ev_o.dat_pls = cur_bit_q;
        ev_o.dir     = classify(prev_bit_q, cur_bit_q, bit_i);
    end

endmodule

// File: rtl/precomp_sched.sv
module precomp_sched
    import fdc_precomp_pkg::*;
#(
    parameter int NOM = 6,
    parameter int LEN = 61,
    parameter int DW  = 3,
    parameter int HW  = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  cell_ev_t      ev_i,
    input  logic [DW-1:0] dly_i,
    input  logic [HW-1:0] half_i,
    output logic          pulse_o
);

    localparam int IW = $clog2(LEN);

    logic [LEN-1:0] sched_q;
    logic [LEN-1:0] mark;
    logic [IW-1:0]  data_idx;

    always_comb begin
        int pos;
        pos = int'(half_i) + NOM;
        if (ev_i.dir == SHIFT_EARLY)
            pos = pos - int'(dly_i);
        else if (ev_i.dir == SHIFT_LATE)
            pos = pos + int'(dly_i);
        data_idx = IW'(pos);
    end

    always_comb begin
        mark = '0;
        if (ev_i.valid && ev_i.clk_pls)
            mark[NOM] = 1'b1;
        if (ev_i.valid && ev_i.dat_pls)
            mark[data_idx] = 1'b1;
    end

    // Timeline: slot k of the register fires k edges after it is written.
    always_ff @(posedge clk) begin
        if (rst)
            sched_q <= '0;
        else
            sched_q <= {1'b0, sched_q[LEN-1:1]} | mark;
    end

    assign pulse_o = sched_q[0];

    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !pulse_o);

    assert_clock_slot_R2: assert property (@(posedge clk) disable iff (rst)
        (ev_i.valid && ev_i.clk_pls) |=> sched_q[NOM]);

    assert_early_slot_R4: assert property (@(posedge clk) disable iff (rst)
        (ev_i.valid && ev_i.dat_pls && ev_i.dir == SHIFT_EARLY)
        |=> sched_q[int'($past(half_i)) + NOM - int'($past(dly_i))]);

    assert_single_width_R9: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o);

endmodule

// File: rtl/mfm_precomp.sv
module mfm_precomp
    import fdc_precomp_pkg::*;
#(
    parameter int MAX_DLY  = 6,
    parameter int DEF_SLOW = 3,
    parameter int DEF_FAST = 1,
    parameter int HALF_R0  = 24,
    parameter int HALF_R1  = 40,
    parameter int HALF_R2  = 48,
    parameter int HALF_R3  = 12,
    parameter int SET_W    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_stb_i,
    input  logic             bit_i,
    input  logic             clk_pls_i,
    input  logic [1:0]       rate_i,
    input  logic [SET_W-1:0] pc_set_i,
    input  logic             pc_en_i,
    output logic             wr_pulse_o
);

    localparam int NOM      = MAX_DLY;
    localparam int HALF_MAX = max4(HALF_R0, HALF_R1, HALF_R2, HALF_R3);
    localparam int LEN      = HALF_MAX + 2 * MAX_DLY + 1;
    localparam int DW       = $clog2(MAX_DLY + 1);
    localparam int HW       = $clog2(HALF_MAX + 1);

    cell_ev_t      ev;
    logic [DW-1:0] dly;
    logic [HW-1:0] half;

    precomp_window u_window (
        .clk    (clk),
        .rst    (rst),
        .stb_i  (bit_stb_i),
        .bit_i  (bit_i),
        .clkp_i (clk_pls_i),
        .ev_o   (ev)
    );

    precomp_delay_sel #(
        .MAX_DLY (MAX_DLY), .DEF_SLOW (DEF_SLOW), .DEF_FAST (DEF_FAST),
        .HALF_R0 (HALF_R0), .HALF_R1 (HALF_R1), .HALF_R2 (HALF_R2),
        .HALF_R3 (HALF_R3), .SET_W (SET_W), .DW (DW), .HW (HW)
    ) u_dsel (
        .rate_i (rate_i),
        .set_i  (pc_set_i),
        .en_i   (pc_en_i),
        .dly_o  (dly),
        .half_o (half)
    );

    precomp_sched #(.NOM (NOM), .LEN (LEN), .DW (DW), .HW (HW)) u_sched (
        .clk     (clk),
        .rst     (rst),
        .ev_i    (ev),
        .dly_i   (dly),
        .half_i  (half),
        .pulse_o (wr_pulse_o)
    );

    assert_off_nominal_R8: assert property (@(posedge clk) disable iff (rst)
        (ev.valid && ev.dat_pls && (!pc_en_i || pc_set_i == '1))
        |=> u_sched.sched_q[int'($past(half)) + NOM]);

    assert_default_delay_R6: assert property (@(posedge clk) disable iff (rst)
        (ev.valid && pc_en_i && pc_set_i == '0)
        |-> (int'(dly) == ((rate_i == 2'd3) ? DEF_FAST : DEF_SLOW)));

endmodule

// File: tb/mfm_precomp_tb_top.sv
`timescale 1ns/1ps
module mfm_precomp_tb_top;

    localparam int NOM = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_stb = 1'b0;
    logic       bit_v = 1'b0;
    logic       clkp = 1'b0;
    logic [1:0] rate = 2'd0;
    logic [2:0] pset = 3'd0;
    logic       pen = 1'b1;
    logic       wr_pulse;

    int n_chk = 0;
    int n_bad = 0;
    int t = 0;
    bit done = 1'b0;

    int    exp_t[$];
    string exp_tag[$];

    // bench model of the bit window
    bit m_have = 0;
    bit m_prev = 0;
    bit m_cur = 0;
    bit m_clk = 0;
    bit m_lastbit = 0;

    always #2 clk = ~clk;

    mfm_precomp dut_i (
        .clk        (clk),
        .rst        (rst),
        .bit_stb_i  (bit_stb),
        .bit_i      (bit_v),
        .clk_pls_i  (clkp),
        .rate_i     (rate),
        .pc_set_i   (pset),
        .pc_en_i    (pen),
        .wr_pulse_o (wr_pulse)
    );

    function automatic int half_of(input int r);
        case (r)
            0: return 24;
            1: return 40;
            2: return 48;
            default: return 12;
        endcase
    endfunction

    function automatic int dly_of(input int r, input int s, input bit en);
        if (!en || s == 7) return 0;
        if (s == 0) return (r == 3) ? 1 : 3;
        return s;
    endfunction

    function automatic string dtag(input int s, input bit en);
        if (!en || s == 7) return "R8";
        if (s == 0) return "R6";
        return "R7";
    endfunction

    task automatic tick();
        @(negedge clk);
        t++;
        if (!rst && wr_pulse) begin
            n_chk++;
            if (exp_t.size() == 0) begin
                n_bad++;
                $display("FAIL R9: unexpected pulse at t=%0d (actual) none expected (expected)", t);
            end else begin
                int    et;
                string tg;
                et = exp_t.pop_front();
                tg = exp_tag.pop_front();
                if (et != t) begin
                    n_bad++;
                    $display("FAIL %s: pulse at t=%0d actual, expected t=%0d", tg, t, et);
                end
            end
        end
    endtask

    // Drive one cell strobe at the current negedge and predict what it releases.
    task automatic send_cell(input bit b);
        bit cp;
        int h;
        int d;
        int s;
        string kt;
        cp = !m_lastbit && !b;
        if (m_have) begin
            h = half_of(int'(rate));
            d = dly_of(int'(rate), int'(pset), pen);
            if (m_clk) begin
                exp_t.push_back(t + 1 + NOM);
                exp_tag.push_back("R2/R9");
            end
            if (m_cur) begin
                if (m_prev && !b) begin s = -d; kt = "R4"; end
                else if (!m_prev && b) begin s = d; kt = "R5"; end
                else begin s = 0; kt = "R3"; end
                exp_t.push_back(t + 1 + h + NOM + s);
                exp_tag.push_back({kt, "/", dtag(int'(pset), pen)});
            end
        end
        m_prev = m_cur;
        m_cur = b;
        m_clk = cp;
        m_have = 1;
        m_lastbit = b;
        bit_stb = 1'b1;
        bit_v = b;
        clkp = cp;
        tick();
        bit_stb = 1'b0;
        for (int i = 1; i < 2 * half_of(int'(rate)); i++) tick();
    endtask

    task automatic run_segment(input int r, input int s, input bit en);
        bit pat[8];
        for (int i = 0; i < 80; i++) tick();
        rate = 2'(r);
        pset = 3'(s);
        pen = en;
        pat = '{0, 1, 1, 0, 1, 1, 1, 0};
        for (int i = 0; i < 8; i++) send_cell(pat[i]);
        for (int i = 0; i < 8; i++) send_cell(1'($urandom % 2));
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 5; i++) begin
            tick();
            n_chk++;
            if (wr_pulse !== 1'b0) begin
                n_bad++;
                $display("FAIL R1: pulse in reset actual=%b expected=0", wr_pulse);
            end
        end
        rst = 1'b0;
        for (int i = 0; i < 20; i++) begin
            tick();
            n_chk++;
            if (wr_pulse !== 1'b0) begin
                n_bad++;
                $display("FAIL R1: pulse after reset actual=%b expected=0", wr_pulse);
            end
        end
        for (int r = 0; r < 4; r++)
            for (int s = 0; s < 8; s++)
                run_segment(r, s, 1'b1);
        run_segment(3, 6, 1'b0);
        run_segment(0, 4, 1'b0);
        run_segment(2, 0, 1'b0);
        for (int i = 0; i < 120; i++) tick();
        while (exp_t.size() != 0) begin
            int    et;
            string tg;
            et = exp_t.pop_front();
            tg = exp_tag.pop_front();
            n_chk++;
            n_bad++;
            $display("FAIL %s: no pulse (actual), expected t=%0d", tg, et);
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 190000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish (actual hung, expected done)");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule